// File: doc/BRIEF.md
# Three-Write Three-Read Pumped Memory

This block is a stall-free memory with three write ports and three read ports, all usable in every kernel clock cycle. It stores identical contents in three replicates. A write on any port goes to every replicate. Each read port has its own replicate, so the three reads never compete with each other.

Each replicate is an inferred dual-port array clocked by a memory clock at twice the kernel rate. In every kernel cycle each replicate therefore has four port slots. In the first memory cycle, both physical ports carry write ports 0 and 1. In the second memory cycle, one port carries write port 2 and the other carries that replicate's read.

All port requests are first registered in the kernel domain. Read results are registered back into the kernel domain. A read is answered two kernel cycles after its address is presented, and the answer already includes every write presented in the same cycle. The memory clock must be phase-aligned with the kernel clock: every kernel rising edge coincides with a memory rising edge.

Top module: `pumped_mem3`

## Requirements
- R1: While `rst` is high, all read data outputs are zero.
- R2: A write accepted on any write port is returned by all three read ports when they read that address.
- R3: Read data for an address presented before kernel edge k appears on `rd_data` right after kernel edge k+2 and holds until the next kernel edge. Reads may be issued back to back in every cycle.
- R4: A read presented in the same kernel cycle as a write to the same address returns the newly written data.
- R5: When writes in one kernel cycle target the same address, the highest-numbered enabled port wins: port 2 beats ports 1 and 0, and port 1 beats port 0.
- R6: The three read ports take independent addresses in the same cycle and each returns its own location. Read port i occupies bits [i*DW +: DW] of `rd_data`, and write port i occupies slice i of `wr_addr` and `wr_data` in the same way.
- R7: A write port whose bit in `wr_en` is low leaves memory contents unchanged, whatever its address and data.
- R8: The internal slot selector alternates between the write-pair slot and the write-plus-read slot on every memory clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_k | input | 1 | Kernel clock |
| clk_m | input | 1 | Memory clock, twice the kernel rate, rising edges aligned with clk_k |
| rst | input | 1 | Synchronous active-high reset, kernel domain |
| wr_en | input | 3 | Write enable, one bit per write port |
| wr_addr | input | 3*AW | Write addresses, port i in slice i |
| wr_data | input | 3*DW | Write data, port i in slice i |
| rd_addr | input | NRD*AW | Read addresses, port i in slice i |
| rd_data | output | NRD*DW | Read data, port i in slice i |

## Verification
Every read result is due exactly two kernel edges after the edge that captured its address. The bench keeps a two-stage queue of expected words, computed from a behavioural model that applies the cycle's writes in port order before answering that cycle's reads. Just after each kernel edge, it compares `rd_data` with the entry that has aged two stages. The reset check samples just after edges while `rst` is held. Directed collision and disabled-write cycles pass through the same queue, so their results are judged on the same due cycle as the random traffic.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_NUM_WR = 3;

  // memory-clock slot within one kernel cycle
  typedef enum logic {
    SLOT_TAIL = 1'b0,  // write port 2 plus the replicate's read
    SLOT_PAIR = 1'b1   // write ports 0 and 1
  } slot_e;

  // read-during-write on the tail slot: new data wins on an address match
  function automatic logic [63:0] pick_newest(input logic hit,
                                              input logic [63:0] fresh,
                                              input logic [63:0] stored);
    return hit ? fresh : stored;
  endfunction
endpackage

// File: rtl/pm_phase.sv
module pm_phase import pm_pkg::*; (
  input  logic  clk_k,
  input  logic  clk_m,
  input  logic  rst,
  output slot_e slot
);
  logic tgl_k = 1'b0;
  logic tgl_seen = 1'b0;

  always_ff @(posedge clk_k) tgl_k <= ~tgl_k;
  always_ff @(posedge clk_m) tgl_seen <= tgl_k;

  // a toggle not yet seen marks the first memory edge after a kernel edge
  assign slot = (tgl_k != tgl_seen) ? SLOT_PAIR : SLOT_TAIL;

  p_slot_alternates_r8: assert property (@(posedge clk_m) disable iff (rst)
    (slot == SLOT_PAIR) |=> (slot == SLOT_TAIL));
  p_slot_returns_r8: assert property (@(posedge clk_m) disable iff (rst)
    (slot == SLOT_TAIL) |=> (slot == SLOT_PAIR));
endmodule

// File: rtl/pm_capture.sv
module pm_capture import pm_pkg::*; #(
  parameter int AW  = 9,
  parameter int DW  = 32,
  parameter int NRD = 3
) (
  input  logic                    clk_k,
  input  logic                    rst,
  input  logic [PM_NUM_WR-1:0]    wr_en,
  input  logic [PM_NUM_WR*AW-1:0] wr_addr,
  input  logic [PM_NUM_WR*DW-1:0] wr_data,
  input  logic [NRD*AW-1:0]       rd_addr,
  output logic [PM_NUM_WR-1:0]    q_en,
  output logic [PM_NUM_WR*AW-1:0] q_waddr,
  output logic [PM_NUM_WR*DW-1:0] q_wdata,
  output logic [NRD*AW-1:0]       q_raddr
);
  always_ff @(posedge clk_k) begin
    if (rst) begin
      q_en    <= '0;
      q_waddr <= '0;
      q_wdata <= '0;
      q_raddr <= '0;
    end else begin
      q_en    <= wr_en;
      q_waddr <= wr_addr;
      q_wdata <= wr_data;
      q_raddr <= rd_addr;
    end
  end
endmodule

// File: rtl/pm_replica.sv
module pm_replica import pm_pkg::*; #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic                    clk_m,
  input  logic                    rst,
  input  slot_e                   slot,
  input  logic [PM_NUM_WR-1:0]    we,
  input  logic [PM_NUM_WR*AW-1:0] wa,
  input  logic [PM_NUM_WR*DW-1:0] wd,
  input  logic [AW-1:0]           ra,
  output logic [DW-1:0]           rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] a0, a1, a2;
  logic [DW-1:0] d0, d1, d2;
  logic          tail_hit;
  logic [63:0]   pick;

  assign a0 = wa[0*AW +: AW];
  assign a1 = wa[1*AW +: AW];
  assign a2 = wa[2*AW +: AW];
  assign d0 = wd[0*DW +: DW];
  assign d1 = wd[1*DW +: DW];
  assign d2 = wd[2*DW +: DW];

  // write port 2 hitting this cycle's read address
  assign tail_hit = we[2] && (a2 == ra);
  assign pick = pick_newest(tail_hit, 64'(d2), 64'(mem[ra]));

  // physical port A: write 0 then write 2; port B: write 1 then read
  always_ff @(posedge clk_m) begin
    if (slot == SLOT_PAIR) begin
      if (we[0]) mem[a0] <= d0;
      if (we[1]) mem[a1] <= d1;
    end else begin
      if (we[2]) mem[a2] <= d2;
    end
  end

  always_ff @(posedge clk_m) begin
    if (slot == SLOT_TAIL) rq <= pick[DW-1:0];
  end

  p_tail_forward_r4: assert property (@(posedge clk_m) disable iff (rst)
    (slot == SLOT_TAIL && tail_hit) |=> (rq == $past(d2)));
  p_pair_order_r5: assert property (@(posedge clk_m) disable iff (rst)
    (slot == SLOT_PAIR && we[0] && we[1] && a0 == a1)
      |=> (mem[$past(a1)] == $past(d1)));
endmodule

// File: rtl/pumped_mem3.sv
module pumped_mem3 import pm_pkg::*; #(
  parameter int AW  = 9,
  parameter int DW  = 32,
  parameter int NRD = 3
) (
  input  logic                    clk_k,
  input  logic                    clk_m,
  input  logic                    rst,
  input  logic [PM_NUM_WR-1:0]    wr_en,
  input  logic [PM_NUM_WR*AW-1:0] wr_addr,
  input  logic [PM_NUM_WR*DW-1:0] wr_data,
  input  logic [NRD*AW-1:0]       rd_addr,
  output logic [NRD*DW-1:0]       rd_data
);
  slot_e                   slot;
  logic [PM_NUM_WR-1:0]    q_en;
  logic [PM_NUM_WR*AW-1:0] q_waddr;
  logic [PM_NUM_WR*DW-1:0] q_wdata;
  logic [NRD*AW-1:0]       q_raddr;
  logic [NRD*DW-1:0]       rep_q;

  pm_phase u_phase (.clk_k(clk_k), .clk_m(clk_m), .rst(rst), .slot(slot));

  pm_capture #(.AW(AW), .DW(DW), .NRD(NRD)) u_cap (
    .clk_k(clk_k), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .q_en(q_en), .q_waddr(q_waddr), .q_wdata(q_wdata), .q_raddr(q_raddr)
  );

  // one replicate per read port, every write broadcast to all
  for (genvar g = 0; g < NRD; g++) begin : g_rep
    pm_replica #(.AW(AW), .DW(DW)) u_rep (
      .clk_m(clk_m), .rst(rst), .slot(slot),
      .we(q_en), .wa(q_waddr), .wd(q_wdata),
      .ra(q_raddr[g*AW +: AW]),
      .rq(rep_q[g*DW +: DW])
    );
  end

  // return to the kernel domain
  always_ff @(posedge clk_k) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rep_q;
  end

  p_reset_clear_r1: assert property (@(posedge clk_k) disable iff (rst)
    $past(rst) |-> (rd_data == '0));
endmodule

// File: tb/sim_pumped_mem3.sv
module sim_pumped_mem3;
  localparam int CLK_PERIOD = 8;
  localparam int AW = 9;
  localparam int DW = 32;
  localparam int NRD = 3;
  localparam int WIN = 16;

  logic clk_k = 1'b0;
  logic clk_m = 1'b1;
  logic rst = 1'b1;
  logic [2:0]       wr_en = '0;
  logic [3*AW-1:0]  wr_addr = '0;
  logic [3*DW-1:0]  wr_data = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD*DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] e1 [NRD];
  logic [DW-1:0] e2 [NRD];
  string t1, t2;
  bit v1 = 0, v2 = 0;

  pumped_mem3 #(.AW(AW), .DW(DW), .NRD(NRD)) u0 (
    .clk_k(clk_k), .clk_m(clk_m), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk_k = ~clk_k;
  always #(CLK_PERIOD/4) clk_m = ~clk_m;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [DW-1:0] rd_slice(input int i);
    return rd_data[i*DW +: DW];
  endfunction

  // one kernel cycle: drive, capture, model in port order, check the due result
  task automatic step(input bit [2:0] en, input int a0, input int a1, input int a2,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [DW-1:0] d2,
                      input int r0, input int r1, input int r2, input string tag);
    int wa [3];
    logic [DW-1:0] wd [3];
    int ra [3];
    logic [DW-1:0] fresh [NRD];
    wa = '{a0, a1, a2};
    wd = '{d0, d1, d2};
    ra = '{r0, r1, r2};
    wr_en = en;
    for (int p = 0; p < 3; p++) begin
      wr_addr[p*AW +: AW] = AW'(wa[p]);
      wr_data[p*DW +: DW] = wd[p];
    end
    for (int p = 0; p < NRD; p++) rd_addr[p*AW +: AW] = AW'(ra[p]);
    @(posedge clk_k);
    for (int p = 0; p < 3; p++) if (en[p]) model[wa[p]] = wd[p];
    for (int p = 0; p < NRD; p++) fresh[p] = model[ra[p]];
    #1;
    if (v2) begin
      for (int p = 0; p < NRD; p++) begin
        checks++;
        if (rd_slice(p) !== e2[p]) begin
          errors++;
          $display("FAIL %s/R3 port %0d actual %h expected %h", t2, p, rd_slice(p), e2[p]);
        end
      end
    end
    e2 = e1; t2 = t1; v2 = v1;
    e1 = fresh; t1 = tag; v1 = 1;
  endtask

  task automatic idle(input string tag);
    step(3'b000, 0, 0, 0, '0, '0, '0, 0, 1, 2, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset holds outputs at zero
    for (int c = 0; c < 4; c++) begin
      @(posedge clk_k); #1;
      checks++;
      if (rd_data !== '0) begin
        errors++;
        $display("FAIL R1 reset output actual %h expected 0", rd_data);
      end
    end
    rst = 1'b0;

    // R2: fill the window, each write read back on every port in the same cycle
    for (int a = 0; a < WIN; a += 3)
      step(3'b111, a, a + 1, a + 2, $urandom, $urandom, $urandom, a, a + 1, a + 2, "R2");
    for (int a = 0; a < WIN; a++) step(3'b000, 0, 0, 0, '0, '0, '0, a, a, a, "R2");

    // R4: same-cycle read after write, each port
    step(3'b001, 3, 0, 0, 32'hA0A0_0003, '0, '0, 3, 3, 3, "R4");
    step(3'b010, 0, 7, 0, '0, 32'hB1B1_0007, '0, 7, 7, 7, "R4");
    step(3'b100, 0, 0, 9, '0, '0, 32'hC2C2_0009, 9, 9, 9, "R4");
    // R5: collisions resolved by port order
    step(3'b111, 5, 5, 5, 32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 5, 5, 5, "R5");
    step(3'b011, 6, 6, 0, 32'h4444_0000, 32'h5555_0000, '0, 6, 6, 6, "R5");
    step(3'b101, 8, 0, 8, 32'h6666_0000, '0, 32'h7777_0000, 8, 8, 8, "R5");
    step(3'b000, 0, 0, 0, '0, '0, '0, 5, 6, 8, "R5");
    // R7: disabled ports with live address and data
    step(3'b000, 2, 2, 2, 32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003, 2, 2, 2, "R7");
    step(3'b000, 2, 4, 1, 32'hDEAD_0004, 32'hDEAD_0005, 32'hDEAD_0006, 2, 4, 1, "R7");
    // R6: distinct simultaneous reads
    step(3'b000, 0, 0, 0, '0, '0, '0, 15, 0, 10, "R6");
    step(3'b000, 0, 0, 0, '0, '0, '0, 1, 12, 4, "R6");

    // R3/R6: random back-to-back traffic in a small window
    for (int n = 0; n < 600; n++)
      step(3'($urandom), $urandom % WIN, $urandom % WIN, $urandom % WIN,
           $urandom, $urandom, $urandom,
           $urandom % WIN, $urandom % WIN, $urandom % WIN, "R6");
    idle("R3");
    idle("R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule